// File: doc/BRIEF.md
# Prefix-Operand Stack Processor Core

This block is a small 32-bit processor core whose instructions are single bytes. The upper nibble of each byte picks a direct function and the lower nibble carries four bits of data. Operands wider than four bits are built by chaining prefix bytes: each prefix merges its nibble into an operand register and shifts the result up, so the next instruction sees a wider operand. Arithmetic and stack manipulation reach the core through an operate function, which treats the accumulated operand as a secondary opcode.

Values live on a three-entry evaluation stack (A on top, then B, then C). Local variables sit in memory at word offsets from a workspace pointer, which is fixed at reset to a set distance below the top of memory. The core uses one synchronous memory port. A read returns the 32-bit word that holds the requested byte address one cycle after the request. Instructions are taken from that word in little-endian byte order. An instruction the core does not implement stops it with a sticky flag. The register file is brought out so that a test harness can see the state once a program has run.

Top module: `tpx_core`

## Requirements
- R1: While reset is held and right after it, A, B, C, the operand register and the instruction pointer read 0, the workspace pointer reads MEM_BYTES minus WS_GAP (2048 by default), and the illegal-halt flag is low.
- R2: Each instruction is the byte at the instruction pointer's byte address, taken from the fetched word in little-endian order (byte 0 is the least significant). Its upper nibble is the function code and its lower nibble is the data. Every completed instruction advances the instruction pointer by exactly one.
- R3: Function 0x2 (positive prefix) loads the operand register with (operand register OR data) shifted left by 4.
- R4: Function 0x6 (negative prefix) loads the operand register with the bitwise complement of (operand register OR data), shifted left by 4.
- R5: Function 0x4 (load constant) pushes the operand (operand register OR data). C takes the old B, B takes the old A, and A takes the operand.
- R6: Function 0x7 (load local) pushes the memory word at workspace pointer + 4 × operand.
- R7: Function 0xD (store local) writes A as a full word to workspace pointer + 4 × operand, then pops the stack: A takes B, B takes C, and C is unchanged.
- R8: Every instruction other than the two prefixes clears the operand register once it completes, so a prefix never carries past the instruction it extends.
- R9: Function 0xF (operate) with operand 0x05 sets A to B + A and with operand 0x0C sets A to B − A, both modulo 2^32. Both then set B to C and leave C unchanged.
- R10: Operate with operand 0x00 swaps A and B and leaves C unchanged.
- R11: Operate with any other operand, or any direct function other than 0x2, 0x4, 0x6, 0x7, 0xD and 0xF, raises the illegal-halt flag. No register changes, the instruction pointer stays on the offending byte, and the core makes no further memory access until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| memAddr | output | 32 | Byte address of the current memory access |
| memRead | output | 1 | Read request; the word arrives on memRdata on the next cycle |
| memWrite | output | 1 | Full-word write of memWdata at memAddr |
| memWdata | output | 32 | Write data (top of stack) |
| memRdata | input | 32 | Read data of the word holding memAddr, one cycle after memRead |
| regA | output | 32 | Stack top |
| regB | output | 32 | Stack second entry |
| regC | output | 32 | Stack third entry |
| wsPtr | output | 32 | Workspace pointer |
| opReg | output | 32 | Operand register |
| instPtr | output | 32 | Instruction pointer (byte address) |
| illegalHalt | output | 1 | Sticky flag: an unimplemented instruction stopped the core |

## Verification
The bench assembles short programs in which constants need zero to several positive or negative prefix bytes. This includes values at the sign boundary and all-ones values. A core that shifted before merging the nibble, or that skipped the complement on a negative prefix, would load a wrong constant. A core that failed to clear the operand register would merge a stale prefix into the next load. Arithmetic runs over pairs that wrap in both directions and checks operand order, since a swapped subtract gives A − B. It also checks that C survives the pop, so a core that shifted zero into C would be caught. Store and load go through large prefixed offsets to catch a missing ×4 scale. Illegal opcodes are checked for a frozen instruction pointer, a preserved operand register and a silent memory port.

// File: rtl/tpx_pkg.sv
package tpx_pkg;

  // Direct function codes (upper nibble of the instruction byte)
  localparam logic [3:0] FN_PFIX = 4'h2;
  localparam logic [3:0] FN_LDC  = 4'h4;
  localparam logic [3:0] FN_NFIX = 4'h6;
  localparam logic [3:0] FN_LDL  = 4'h7;
  localparam logic [3:0] FN_STL  = 4'hD;
  localparam logic [3:0] FN_OPR  = 4'hF;

  // Secondary codes carried by the operand of the operate function
  localparam logic [31:0] SEC_REV = 32'h0000_0000;
  localparam logic [31:0] SEC_ADD = 32'h0000_0005;
  localparam logic [31:0] SEC_SUB = 32'h0000_000C;

  typedef enum logic [1:0] {
    ST_FETCH,
    ST_EXEC,
    ST_LOAD,
    ST_HALT
  } tpxState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic pfix;
    logic nfix;
    logic pushConst;
    logic pushMem;
    logic popStore;
    logic add;
    logic sub;
    logic rev;
    logic clrOreg;
    logic incIp;
  } tpxStrobes_t;

endpackage

// File: rtl/tpx_control.sv
module tpx_control
  import tpx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  fn,
  input  logic [31:0] operand,
  output tpxStrobes_t st,
  output logic        memRead,
  output logic        memWrite,
  output logic        dataAddrSel,
  output logic        illegalHalt
);

  tpxState_e state, nextState;
  logic      bad;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_FETCH;
    else       state <= nextState;
  end

  always_comb begin
    st          = '0;
    memRead     = 1'b0;
    memWrite    = 1'b0;
    dataAddrSel = 1'b0;
    bad         = 1'b0;
    nextState   = state;
    unique case (state)
      ST_FETCH: begin
        memRead   = 1'b1;
        nextState = ST_EXEC;
      end
      ST_EXEC: begin
        unique case (fn)
          FN_PFIX: st.pfix = 1'b1;
          FN_NFIX: st.nfix = 1'b1;
          FN_LDC:  st.pushConst = 1'b1;
          FN_LDL: begin
            memRead     = 1'b1;
            dataAddrSel = 1'b1;
          end
          FN_STL: begin
            memWrite    = 1'b1;
            dataAddrSel = 1'b1;
            st.popStore = 1'b1;
          end
          FN_OPR: begin
            if (operand == SEC_ADD)      st.add = 1'b1;
            else if (operand == SEC_SUB) st.sub = 1'b1;
            else if (operand == SEC_REV) st.rev = 1'b1;
            else                         bad    = 1'b1;
          end
          default: bad = 1'b1;
        endcase
        st.incIp   = !bad;
        st.clrOreg = !bad && (fn != FN_PFIX) && (fn != FN_NFIX);
        if (bad)               nextState = ST_HALT;
        else if (fn == FN_LDL) nextState = ST_LOAD;
        else                   nextState = ST_FETCH;
      end
      ST_LOAD: begin
        st.pushMem = 1'b1;
        nextState  = ST_FETCH;
      end
      default: nextState = ST_HALT;
    endcase
  end

  assign illegalHalt = (state == ST_HALT);

  AST_ONE_OPERATION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.pfix, st.nfix, st.pushConst, st.pushMem, st.popStore, st.add, st.sub, st.rev})); // R2
  AST_PORT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(memRead && memWrite)); // R7
  AST_LOAD_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_EXEC && fn == FN_LDL) |=> st.pushMem); // R6
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    illegalHalt |=> (illegalHalt && !memRead && !memWrite)); // R11

endmodule

// File: rtl/tpx_datapath.sv
module tpx_datapath
  import tpx_pkg::*;
#(
  parameter logic [31:0] WPTR_RESET = 32'd2048,
  parameter logic [31:0] IP_RESET   = 32'd0
) (
  input  logic        clk,
  input  logic        rstN,
  input  tpxStrobes_t st,
  input  logic        dataAddrSel,
  input  logic [31:0] memRdata,
  output logic [3:0]  fn,
  output logic [31:0] operand,
  output logic [31:0] memAddr,
  output logic [31:0] memWdata,
  output logic [31:0] regA,
  output logic [31:0] regB,
  output logic [31:0] regC,
  output logic [31:0] wsPtr,
  output logic [31:0] opReg,
  output logic [31:0] instPtr
);

  logic [7:0]  instrByte;
  logic [31:0] localAddr;

  // Little-endian byte lane of the fetched word
  assign instrByte = memRdata[{instPtr[1:0], 3'b000} +: 8];
  assign fn        = instrByte[7:4];
  assign operand   = opReg | {28'h0, instrByte[3:0]};
  assign localAddr = wsPtr + {operand[29:0], 2'b00};
  assign memAddr   = dataAddrSel ? localAddr : instPtr;
  assign memWdata  = regA;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regA    <= '0;
      regB    <= '0;
      regC    <= '0;
      opReg   <= '0;
      instPtr <= IP_RESET;
      wsPtr   <= WPTR_RESET;
    end else begin
      if (st.pfix)    opReg <= {operand[27:0], 4'h0};
      if (st.nfix)    opReg <= {~operand[27:0], 4'h0};
      if (st.clrOreg) opReg <= '0;
      if (st.incIp)   instPtr <= instPtr + 32'd1;
      if (st.pushConst || st.pushMem) begin
        regA <= st.pushMem ? memRdata : operand;
        regB <= regA;
        regC <= regB;
      end
      if (st.popStore) begin
        regA <= regB;
        regB <= regC;
      end
      if (st.add || st.sub) begin
        regA <= st.add ? (regB + regA) : (regB - regA);
        regB <= regC;
      end
      if (st.rev) begin
        regA <= regB;
        regB <= regA;
      end
    end
  end

  AST_PFIX_MERGE: assert property (@(posedge clk) disable iff (!rstN)
    st.pfix |=> (opReg[3:0] == 4'h0 && opReg[7:4] == $past(operand[3:0]))); // R3
  AST_NFIX_MERGE: assert property (@(posedge clk) disable iff (!rstN)
    st.nfix |=> (opReg[3:0] == 4'h0 && opReg[7:4] == ~$past(operand[3:0]))); // R4
  AST_PUSH_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    (st.pushConst || st.pushMem) |=> (regB == $past(regA) && regC == $past(regB))); // R5
  AST_OREG_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    st.clrOreg |=> (opReg == 32'h0)); // R8
  AST_POP_KEEPS_C: assert property (@(posedge clk) disable iff (!rstN)
    (st.popStore || st.add || st.sub) |=> (regB == $past(regC) && $stable(regC))); // R9
  AST_REV_SWAP: assert property (@(posedge clk) disable iff (!rstN)
    st.rev |=> (regA == $past(regB) && regB == $past(regA) && $stable(regC))); // R10
  AST_IP_STEP: assert property (@(posedge clk) disable iff (!rstN)
    st.incIp |=> (instPtr == $past(instPtr) + 32'd1)); // R2
  AST_WPTR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    $stable(wsPtr)); // R6

endmodule

// File: rtl/tpx_core.sv
module tpx_core
  import tpx_pkg::*;
#(
  parameter int unsigned MEM_BYTES = 4096,
  parameter int unsigned WS_GAP    = 2048,
  parameter int unsigned RESET_IP  = 0
) (
  input  logic        clk,
  input  logic        rstN,
  output logic [31:0] memAddr,
  output logic        memRead,
  output logic        memWrite,
  output logic [31:0] memWdata,
  input  logic [31:0] memRdata,
  output logic [31:0] regA,
  output logic [31:0] regB,
  output logic [31:0] regC,
  output logic [31:0] wsPtr,
  output logic [31:0] opReg,
  output logic [31:0] instPtr,
  output logic        illegalHalt
);

  localparam logic [31:0] WPTR_RESET = 32'(MEM_BYTES - WS_GAP);
  localparam logic [31:0] IP_RESET   = 32'(RESET_IP);

  tpxStrobes_t st;
  logic        dataAddrSel;
  logic [3:0]  fn;
  logic [31:0] operand;

  tpx_control u_control (
    .clk         (clk),
    .rstN        (rstN),
    .fn          (fn),
    .operand     (operand),
    .st          (st),
    .memRead     (memRead),
    .memWrite    (memWrite),
    .dataAddrSel (dataAddrSel),
    .illegalHalt (illegalHalt)
  );

  tpx_datapath #(
    .WPTR_RESET (WPTR_RESET),
    .IP_RESET   (IP_RESET)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .st          (st),
    .dataAddrSel (dataAddrSel),
    .memRdata    (memRdata),
    .fn          (fn),
    .operand     (operand),
    .memAddr     (memAddr),
    .memWdata    (memWdata),
    .regA        (regA),
    .regB        (regB),
    .regC        (regC),
    .wsPtr       (wsPtr),
    .opReg       (opReg),
    .instPtr     (instPtr)
  );

endmodule

// File: tb/tpx_core_bench.sv
`timescale 1ns/1ps
module tpx_core_bench;

  localparam int WORDS = 1024;
  localparam logic [31:0] WS = 32'd2048;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] memAddr, memWdata, memRdata;
  logic        memRead, memWrite;
  logic [31:0] regA, regB, regC, wsPtr, opReg, instPtr;
  logic        illegalHalt;

  logic [31:0] mem [WORDS];
  logic [31:0] img [WORDS];

  int total = 0;
  int fails = 0;
  int pc = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  tpx_core u_tpx_core (
    .clk(clk), .rstN(rstN), .memAddr(memAddr), .memRead(memRead),
    .memWrite(memWrite), .memWdata(memWdata), .memRdata(memRdata),
    .regA(regA), .regB(regB), .regC(regC), .wsPtr(wsPtr), .opReg(opReg),
    .instPtr(instPtr), .illegalHalt(illegalHalt)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= img[i];
    end else begin
      if (memWrite) mem[memAddr[11:2]] <= memWdata;
      if (memRead)  memRdata <= mem[memAddr[11:2]];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clearImg();
    for (int i = 0; i < WORDS; i++) img[i] = 32'h0;
    pc = 0;
  endtask

  task automatic emit(input logic [7:0] b);
    img[pc >> 2][(pc & 3) * 8 +: 8] = b;
    pc++;
  endtask

  // Emit fn with value v, preceded by the prefix chain it needs
  task automatic emitEnc(input logic [3:0] fnc, input logic [31:0] v);
    logic [3:0] fns [10];
    logic [3:0] nib [10];
    int n = 0;
    int signed cur = v;
    logic [3:0] curFn = fnc;
    bit done = 1'b0;
    for (int g = 0; g < 10 && !done; g++) begin
      if (cur >= 0 && cur < 16) begin
        fns[n] = curFn; nib[n] = cur[3:0]; n++; done = 1'b1;
      end else if (cur >= 16) begin
        fns[n] = curFn; nib[n] = cur[3:0]; n++;
        cur = cur >>> 4; curFn = 4'h2;
      end else begin
        fns[n] = curFn; nib[n] = cur[3:0]; n++;
        cur = (~cur) >>> 4; curFn = 4'h6;
      end
    end
    for (int k = n - 1; k >= 0; k--) emit({fns[k], nib[k]});
  endtask

  // Reset, load image, run until halt
  task automatic runProg(input string tag);
    bit got = 1'b0;
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    for (int c = 0; c < 600 && !got; c++) begin
      @(negedge clk);
      if (illegalHalt) got = 1'b1;
    end
    if (!got) begin
      total++; fails++;
      $display("FAIL %s actual=running expected=halted", tag);
    end
  endtask

  logic [31:0] vals [11];
  logic [31:0] pa [5];
  logic [31:0] pb [5];
  int offs [4];

  initial begin
    vals[0] = 32'd0;          vals[1] = 32'd7;          vals[2] = 32'd15;
    vals[3] = 32'd16;         vals[4] = 32'h1234;       vals[5] = 32'h7FFF_FFFF;
    vals[6] = 32'h8000_0000;  vals[7] = 32'hFFFF_FFFF;  vals[8] = 32'hFFFF_FFF0;
    vals[9] = 32'hFFFF_FFEF;  vals[10] = 32'hDEAD_BEEF;
    pa[0] = 32'd5;  pb[0] = 32'd3;
    pa[1] = 32'd0;  pb[1] = 32'd1;
    pa[2] = 32'hFFFF_FFFF; pb[2] = 32'd1;
    pa[3] = 32'h8000_0000; pb[3] = 32'h7FFF_FFFF;
    pa[4] = 32'h1234_5678; pb[4] = 32'h9ABC_DEF0;
    offs[0] = 0; offs[1] = 1; offs[2] = 20; offs[3] = 300;
    clearImg();

    // R1: state during reset
    repeat (2) @(negedge clk);
    chk("R1 A", regA, 32'h0);
    chk("R1 B", regB, 32'h0);
    chk("R1 C", regC, 32'h0);
    chk("R1 oreg", opReg, 32'h0);
    chk("R1 ip", instPtr, 32'h0);
    chk("R1 wptr", wsPtr, WS);
    chk("R1 halt", {31'h0, illegalHalt}, 32'h0);

    // R5, R3, R4, R2: constants through prefix chains
    for (int i = 0; i < 11; i++) begin
      clearImg();
      emitEnc(4'h4, vals[i]);
      emit(8'h00);
      runProg("R5 ldc");
      chk("R5 ldc A", regA, vals[i]);
      chk("R5 ldc B", regB, 32'h0);
      chk("R2 ip on halt", instPtr, 32'(pc - 1));
      chk("R8 oreg after ldc", opReg, 32'h0);
    end

    // R3 R4: prefix chain left in operand register by an illegal byte
    clearImg();
    emit(8'h23); emit(8'h65); emit(8'h00);
    runProg("R4 chain");
    chk("R4 nfix after pfix", opReg, 32'hFFFF_FCA0);
    clearImg();
    emit(8'h23); emit(8'h25); emit(8'h00);
    runProg("R3 chain");
    chk("R3 pfix twice", opReg, 32'h0000_0350);

    // R8: prefix does not carry past the instruction it extends
    clearImg();
    emit(8'h21); emit(8'h42); emit(8'h43); emit(8'h00);
    runProg("R8");
    chk("R8 A", regA, 32'd3);
    chk("R8 B", regB, 32'h12);

    // R6 R7: store then reload through various offsets
    for (int i = 0; i < 4; i++) begin
      logic [31:0] v1, v2;
      v1 = 32'hA5C3_0000 + 32'(i * 17);
      v2 = 32'h0000_0BEE + 32'(i);
      clearImg();
      emitEnc(4'h4, v1);
      emitEnc(4'hD, 32'(offs[i]));
      emitEnc(4'h4, v2);
      emitEnc(4'h7, 32'(offs[i]));
      emit(8'h00);
      runProg("R6 R7");
      chk("R7 stored word", mem[(WS + 32'(4 * offs[i])) >> 2], v1);
      chk("R6 ldl A", regA, v1);
      chk("R6 ldl B", regB, v2);
      chk("R7 pop C", regC, 32'h0);
    end

    // R7: pop keeps C
    clearImg();
    emit(8'h41); emit(8'h42); emit(8'h43); emit(8'hD0); emit(8'h00);
    runProg("R7 pop");
    chk("R7 A", regA, 32'd2);
    chk("R7 B", regB, 32'd1);
    chk("R7 C", regC, 32'd1);

    // R9 R10: arithmetic and swap sweep
    for (int i = 0; i < 5; i++) begin
      for (int op = 0; op < 3; op++) begin
        clearImg();
        emitEnc(4'h4, 32'h55);
        emitEnc(4'h4, pb[i]);
        emitEnc(4'h4, pa[i]);
        emit(op == 0 ? 8'hF5 : (op == 1 ? 8'hFC : 8'hF0));
        emit(8'h00);
        runProg("R9 R10");
        if (op == 0) begin
          chk("R9 add A", regA, pb[i] + pa[i]);
          chk("R9 add B", regB, 32'h55);
          chk("R9 add C", regC, 32'h55);
        end else if (op == 1) begin
          chk("R9 sub A", regA, pb[i] - pa[i]);
          chk("R9 sub B", regB, 32'h55);
          chk("R9 sub C", regC, 32'h55);
        end else begin
          chk("R10 rev A", regA, pb[i]);
          chk("R10 rev B", regB, pa[i]);
          chk("R10 rev C", regC, 32'h55);
        end
      end
    end

    // R11: unknown secondary opcode freezes the core
    begin
      int acc = 0;
      logic [31:0] ipHold;
      clearImg();
      emit(8'h49);
      emitEnc(4'hF, 32'h2A);
      emit(8'h41);
      runProg("R11");
      chk("R11 flag", {31'h0, illegalHalt}, 32'h1);
      chk("R11 A kept", regA, 32'd9);
      chk("R11 oreg kept", opReg, 32'h20);
      chk("R11 ip on bad byte", instPtr, 32'd2);
      ipHold = instPtr;
      for (int c = 0; c < 10; c++) begin
        @(negedge clk);
        if (memRead || memWrite) acc++;
      end
      chk("R11 no access", 32'(acc), 32'h0);
      chk("R11 ip frozen", instPtr, ipHold);
      chk("R11 still halted", {31'h0, illegalHalt}, 32'h1);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule